// File: doc/BRIEF.md
# Signed Representation Converter

This block translates a signed integer between two's complement and six other encodings: sign-magnitude, ones' complement, offset binary, negabinary (base −2), zig-zag, and the signed-to-code-number mapping used ahead of exponential-Golomb coding. A direction bit picks the path. Encode takes a two's complement word and produces the chosen format. Decode takes a word in the chosen format and returns two's complement.

Each transfer is a single word with a valid strobe. The result appears one clock later, with its own valid and an out-of-range flag. When a value has no encoding in the target format, the block returns an all-zero word and raises the flag. Packing the codes into variable-length bit streams is left to downstream logic.

Top module: `sign_repr_conv`

## Requirements
- R1: The format select uses these codes: 0 sign-magnitude, 1 ones' complement, 2 offset binary, 3 negabinary, 4 zig-zag, 5 code-number mapping. Direction 0 encodes from two's complement and direction 1 decodes to it. outValid is inValid delayed by one clock. outData and outRange load only on a cycle where inValid is high, and hold in all other cycles.
- R2: Sign-magnitude puts the sign in the MSB and the magnitude below it. Decoding 1 followed by all zeros gives 0. Encoding the most negative two's complement value is out of range.
- R3: In ones' complement, a negative value is its sign-magnitude word with every magnitude bit inverted. Decoding all ones gives 0. Encoding the most negative value is out of range.
- R4: Offset binary is two's complement with the MSB inverted, in both directions, and is never out of range.
- R5: Negabinary encode gives bit i the weight (−2)^i. An input with no such representation in WIDTH bits is out of range; for 8 bits, every value above 85 is out of range.
- R6: Negabinary decode returns the weighted sum. A sum outside the two's complement range is out of range; for example, 8'hAA = −170 is out of range.
- R7: Zig-zag maps 0, −1, 1, −2, … to 0, 1, 2, 3, …, decodes as the inverse, and is never out of range.
- R8: The code-number mapping sends k>0 to 2k−1 and k≤0 to −2k. For 8 bits, encoding −128 is out of range, and decoding 255, which stands for +128, is out of range.
- R9: Whenever outRange is high, outData is all zeros.
- R10: Format codes 6 and 7 give outData zero with outRange high.
- R11: After reset, outValid, outData and outRange are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is present |
| inDir | input | 1 | 0 encode, 1 decode |
| inFmt | input | 3 | Format select |
| inData | input | WIDTH | Input word |
| outValid | output | 1 | Result present |
| outData | output | WIDTH | Converted word |
| outRange | output | 1 | Value not representable |

## Verification
The result register loads only under the valid strobe. A wrong enable therefore shows in the very next cycle: either stale data arrives alongside outValid, or the output changes while no valid was given. An error in the digit loop or a range bound affects only particular values, such as the negabinary limits at 85/86 and −130, or the code-number limit at ±128. The vector table probes exactly those neighbours. A missing zero-forcing step appears as a non-zero word beside a raised flag, one cycle after the offending input.

// File: rtl/sign_repr_pkg.sv
package sign_repr_pkg;

  typedef enum logic [2:0] {
    FMT_SIGNMAG = 3'd0,
    FMT_ONESC   = 3'd1,
    FMT_OFFSET  = 3'd2,
    FMT_NEGA    = 3'd3,
    FMT_ZIGZAG  = 3'd4,
    FMT_GOLOMB  = 3'd5
  } fmt_e;

  typedef struct packed {
    logic load;
    logic encode;
    logic fmtOk;
    fmt_e fmt;
  } strobe_t;

endpackage

// File: rtl/srconv_ctrl.sv
module srconv_ctrl
  import sign_repr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inDir,
  input  logic [2:0] inFmt,
  output strobe_t    strobe,
  output logic       outValid
);

  logic armed;

  always_comb begin
    strobe.load   = inValid;
    strobe.encode = ~inDir;
    strobe.fmtOk  = (inFmt <= 3'd5);
    strobe.fmt    = fmt_e'(inFmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      armed    <= 1'b0;
    end else begin
      outValid <= inValid;
      armed    <= 1'b1;
    end
  end

  // R1: result valid trails input valid by one clock
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outValid == $past(inValid)));

endmodule

// File: rtl/srconv_datapath.sv
module srconv_datapath
  import sign_repr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] outData,
  output logic             outRange
);

  localparam int XW = WIDTH + 2;
  localparam logic signed [XW-1:0] ONE    = {{(XW-1){1'b0}}, 1'b1};
  localparam logic signed [XW-1:0] ZERO   = '0;
  localparam logic signed [XW-1:0] TC_MAX = {3'b000, {(WIDTH-1){1'b1}}};
  localparam logic signed [XW-1:0] TC_MIN = {3'b111, {(WIDTH-1){1'b0}}};
  localparam logic signed [XW-1:0] U_MAX  = {2'b00, {WIDTH{1'b1}}};
  localparam logic [WIDTH-1:0]     MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic signed [XW-1:0] sx, ux, mag, v, t, wt, acc, w;
  logic [WIDTH-1:0] res, nextData;
  logic             oor, armed;
  logic             neg;

  always_comb begin
    sx  = {{2{inData[WIDTH-1]}}, inData};
    ux  = {2'b00, inData};
    neg = inData[WIDTH-1];
    mag = neg ? -sx : sx;
    res = '0;
    oor = 1'b0;
    v   = sx;
    t   = '0;
    wt  = ONE;
    acc = '0;
    w   = '0;
    if (!strobe.fmtOk) begin
      oor = 1'b1;
    end else if (strobe.encode) begin
      case (strobe.fmt)
        FMT_SIGNMAG: begin
          oor = (inData == MOST_NEG);
          res = {neg, mag[WIDTH-2:0]};
        end
        FMT_ONESC: begin
          oor = (inData == MOST_NEG);
          res = neg ? {1'b1, ~mag[WIDTH-2:0]} : inData;
        end
        FMT_OFFSET: res = {~inData[WIDTH-1], inData[WIDTH-2:0]};
        FMT_NEGA: begin
          for (int i = 0; i < WIDTH; i++) begin
            res[i] = v[0];
            t = v - {{(XW-1){1'b0}}, v[0]};
            v = -(t >>> 1);
          end
          oor = (v != ZERO);
        end
        FMT_ZIGZAG: res = {inData[WIDTH-2:0], 1'b0} ^ {WIDTH{neg}};
        FMT_GOLOMB: begin
          w   = (sx > ZERO) ? ((sx <<< 1) - ONE) : -(sx <<< 1);
          oor = (w > U_MAX);
          res = w[WIDTH-1:0];
        end
        default: oor = 1'b1;
      endcase
    end else begin
      case (strobe.fmt)
        FMT_SIGNMAG: begin
          w   = {3'b000, inData[WIDTH-2:0]};
          w   = neg ? -w : w;
          res = w[WIDTH-1:0];
        end
        FMT_ONESC: begin
          w   = neg ? -({2'b00, ~inData}) : ux;
          res = w[WIDTH-1:0];
        end
        FMT_OFFSET: res = {~inData[WIDTH-1], inData[WIDTH-2:0]};
        FMT_NEGA: begin
          for (int i = 0; i < WIDTH; i++) begin
            if (inData[i]) acc = acc + wt;
            wt = -(wt <<< 1);
          end
          oor = (acc > TC_MAX) || (acc < TC_MIN);
          res = acc[WIDTH-1:0];
        end
        FMT_ZIGZAG: res = {1'b0, inData[WIDTH-1:1]} ^ {WIDTH{inData[0]}};
        FMT_GOLOMB: begin
          w   = inData[0] ? ((ux + ONE) >>> 1) : -(ux >>> 1);
          oor = (w > TC_MAX);
          res = w[WIDTH-1:0];
        end
        default: oor = 1'b1;
      endcase
    end
    nextData = oor ? '0 : res;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outRange <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (strobe.load) begin
        outData  <= nextData;
        outRange <= oor;
      end
    end
  end

  // R9: a raised flag always comes with a zero word
  assert_zero_on_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    outRange |-> (outData == '0));

  // R1: no load, no change
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(strobe.load)) |-> ($stable(outData) && $stable(outRange)));

  // R4: offset binary always representable
  assert_offset_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strobe.load) && $past(strobe.fmtOk) && $past(strobe.fmt) == FMT_OFFSET)
      |-> !outRange);

  // R7: zig-zag always representable
  assert_zigzag_ok_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strobe.load) && $past(strobe.fmtOk) && $past(strobe.fmt) == FMT_ZIGZAG)
      |-> !outRange);

  // R10: reserved codes flag
  assert_reserved_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strobe.load) && !$past(strobe.fmtOk)) |-> outRange);

endmodule

// File: rtl/sign_repr_conv.sv
module sign_repr_conv
  import sign_repr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inDir,
  input  logic [2:0]       inFmt,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic             outRange
);

  strobe_t strobe;

  srconv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDir    (inDir),
    .inFmt    (inFmt),
    .strobe   (strobe),
    .outValid (outValid)
  );

  srconv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .outData  (outData),
    .outRange (outRange)
  );

endmodule

// File: tb/sign_repr_conv_tb.sv
module sign_repr_conv_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inDir = 1'b0;
  logic [2:0] inFmt = 3'd0;
  logic [7:0] inData = 8'h00;
  logic       outValid;
  logic [7:0] outData;
  logic       outRange;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sign_repr_conv #(.WIDTH(8)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDir(inDir), .inFmt(inFmt),
    .inData(inData), .outValid(outValid), .outData(outData), .outRange(outRange)
  );

  // {dir, fmt, in, expected, expectedRange, requirement}
  localparam int NV = 60;
  localparam logic [24:0] VECS [NV] = '{
    // R2 sign-magnitude
    {1'b0,3'd0,8'h2B,8'h2B,1'b0,4'd2}, {1'b0,3'd0,8'hD5,8'hAB,1'b0,4'd2},
    {1'b0,3'd0,8'h80,8'h00,1'b1,4'd2}, {1'b0,3'd0,8'h00,8'h00,1'b0,4'd2},
    {1'b1,3'd0,8'hAB,8'hD5,1'b0,4'd2}, {1'b1,3'd0,8'h80,8'h00,1'b0,4'd2},
    {1'b1,3'd0,8'h7F,8'h7F,1'b0,4'd2}, {1'b1,3'd0,8'hFF,8'h81,1'b0,4'd2},
    // R3 ones' complement
    {1'b0,3'd1,8'hD5,8'hD4,1'b0,4'd3}, {1'b0,3'd1,8'h80,8'h00,1'b1,4'd3},
    {1'b0,3'd1,8'h05,8'h05,1'b0,4'd3}, {1'b1,3'd1,8'hFF,8'h00,1'b0,4'd3},
    {1'b1,3'd1,8'h80,8'h81,1'b0,4'd3}, {1'b1,3'd1,8'hD4,8'hD5,1'b0,4'd3},
    // R4 offset binary
    {1'b0,3'd2,8'h00,8'h80,1'b0,4'd4}, {1'b0,3'd2,8'h80,8'h00,1'b0,4'd4},
    {1'b0,3'd2,8'h7F,8'hFF,1'b0,4'd4}, {1'b1,3'd2,8'h80,8'h00,1'b0,4'd4},
    {1'b1,3'd2,8'h00,8'h80,1'b0,4'd4},
    // R5 negabinary encode
    {1'b0,3'd3,8'h01,8'h01,1'b0,4'd5}, {1'b0,3'd3,8'h02,8'h06,1'b0,4'd5},
    {1'b0,3'd3,8'hFF,8'h03,1'b0,4'd5}, {1'b0,3'd3,8'h55,8'h55,1'b0,4'd5},
    {1'b0,3'd3,8'h56,8'h00,1'b1,4'd5}, {1'b0,3'd3,8'h80,8'h80,1'b0,4'd5},
    {1'b0,3'd3,8'h7F,8'h00,1'b1,4'd5}, {1'b0,3'd3,8'hFE,8'h02,1'b0,4'd5},
    {1'b0,3'd3,8'h03,8'h07,1'b0,4'd5}, {1'b0,3'd3,8'hFD,8'h0D,1'b0,4'd5},
    // R6 negabinary decode
    {1'b1,3'd3,8'hAA,8'h00,1'b1,4'd6}, {1'b1,3'd3,8'h55,8'h55,1'b0,4'd6},
    {1'b1,3'd3,8'h0D,8'hFD,1'b0,4'd6}, {1'b1,3'd3,8'h80,8'h80,1'b0,4'd6},
    {1'b1,3'd3,8'h82,8'h00,1'b1,4'd6}, {1'b1,3'd3,8'h06,8'h02,1'b0,4'd6},
    // R7 zig-zag
    {1'b0,3'd4,8'h00,8'h00,1'b0,4'd7}, {1'b0,3'd4,8'hFF,8'h01,1'b0,4'd7},
    {1'b0,3'd4,8'h01,8'h02,1'b0,4'd7}, {1'b0,3'd4,8'hFE,8'h03,1'b0,4'd7},
    {1'b0,3'd4,8'h7F,8'hFE,1'b0,4'd7}, {1'b0,3'd4,8'h80,8'hFF,1'b0,4'd7},
    {1'b1,3'd4,8'hFF,8'h80,1'b0,4'd7}, {1'b1,3'd4,8'hFE,8'h7F,1'b0,4'd7},
    {1'b1,3'd4,8'h03,8'hFE,1'b0,4'd7},
    // R8 code-number mapping
    {1'b0,3'd5,8'h01,8'h01,1'b0,4'd8}, {1'b0,3'd5,8'h02,8'h03,1'b0,4'd8},
    {1'b0,3'd5,8'h00,8'h00,1'b0,4'd8}, {1'b0,3'd5,8'hFF,8'h02,1'b0,4'd8},
    {1'b0,3'd5,8'hFE,8'h04,1'b0,4'd8}, {1'b0,3'd5,8'h7F,8'hFD,1'b0,4'd8},
    {1'b0,3'd5,8'h81,8'hFE,1'b0,4'd8}, {1'b0,3'd5,8'h80,8'h00,1'b1,4'd8},
    {1'b1,3'd5,8'h00,8'h00,1'b0,4'd8}, {1'b1,3'd5,8'h01,8'h01,1'b0,4'd8},
    {1'b1,3'd5,8'h02,8'hFF,1'b0,4'd8}, {1'b1,3'd5,8'hFE,8'h81,1'b0,4'd8},
    {1'b1,3'd5,8'hFD,8'h7F,1'b0,4'd8}, {1'b1,3'd5,8'hFF,8'h00,1'b1,4'd8},
    // R10 reserved codes
    {1'b0,3'd6,8'h12,8'h00,1'b1,4'd10}, {1'b1,3'd7,8'h34,8'h00,1'b1,4'd10}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic d, input logic [2:0] f, input logic [7:0] x);
    inValid = 1'b1; inDir = d; inFmt = f; inData = x;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {outValid, outData}, 9'h000);
    check("R11", {8'h00, outRange}, 9'h000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] e;
      e = VECS[i];
      apply(e[24], e[23:21], e[20:13]);
      check($sformatf("R%0d vec%0d", e[3:0], i), {outRange, outData}, {e[4], e[12:5]});
      check("R1 valid", {8'h00, outValid}, 9'h001);
    end

    // R1 hold: no valid, changing input, output frozen
    apply(1'b0, 3'd2, 8'h11);
    held = outData;
    inData = 8'h5A; inFmt = 3'd6;
    @(negedge clk);
    check("R1 noValid", {8'h00, outValid}, 9'h000);
    check("R1 hold", {outRange, outData}, {1'b0, held});
    @(negedge clk);
    check("R1 hold2", {outRange, outData}, {1'b0, 8'h91});

    // R1 back-to-back
    inValid = 1'b1; inDir = 1'b0; inFmt = 3'd4; inData = 8'hFF;
    @(negedge clk);
    check("R1 b2b first", {outValid, outData}, {1'b1, 8'h01});
    inFmt = 3'd1; inData = 8'h80;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 zero word", {outRange, outData}, {1'b1, 8'h00});
    @(negedge clk);
    check("R1 valid drop", {8'h00, outValid}, 9'h000);

    // R11 reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R11 rereset", {outValid, outData}, 9'h000);
    check("R11 rereset flag", {8'h00, outRange}, 9'h000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule